// File: doc/BRIEF.md
# Compare-Match Timer Channel Group

This block holds a small group of periodic timer channels that share one run-control register. Each channel counts prescaled ticks in an up-counter. When the count equals the channel's compare value, the counter returns to zero on the next tick and a sticky match flag is set. If the channel's interrupt is enabled, the flag drives that channel's interrupt line until software clears it. The counter width is a parameter and may be 16 or 32 bits. The 32-bit build also has a wrap flag, which records the counter rolling over from all ones.

Counting is paced by a slow counting clock. The slow clock is represented in the bus clock domain as a one-cycle strobe, `cnt_stb_i`. The channel prescaler divides these strobes. A software write to a counter does not take effect at once. It is held and applied on the second strobe after the write, and reads return the old count until then. Software reaches every register through a simple byte-addressed read/write bus. Read data is registered.

Top module: `cmt_timer_block`

## Requirements
- R1: After reset every counter reads 0, every compare register reads all ones, every control/status register reads 0, the run register reads 0 and every interrupt line is low.
- R2: The run register sits at byte address 0. Channel k occupies byte base (k+1)*16. Inside a channel, control/status, counter and compare are word indices 0, 1 and 2, with words 4 bytes apart in the 32-bit build (2 bytes in the 16-bit build). Read data appears on `bus_rdata_o` one cycle after the read request, with `bus_rvalid_o` high. An unaligned channel address reads as 0.
- R3: Bit k of the run register lets channel k count. While the bit is 0, the counter holds its value.
- R4: Control/status bits 1:0 choose how many count strobes make one tick: code 0 gives 8, code 1 gives 32, code 2 gives 128 and code 3 gives 512.
- R5: On a tick where the counter equals the compare value, the counter becomes 0 and the match flag is set. The match flag is bit 15 in the 32-bit build and bit 7 in the 16-bit build. One period is therefore compare value + 1 ticks.
- R6: In the 32-bit build, a tick that finds the counter at all ones without a match wraps it to 0 and sets the wrap flag at control/status bit 14.
- R7: Writing control/status with 0 in a flag bit clears that flag. Writing 1 there leaves the flag as it was.
- R8: Control/status bit 6 enables the interrupt. The interrupt line is high, one cycle later, while both the match flag and the enable are set. Writing 0 to the enable, or clearing the flag, drops the line.
- R9: A counter write is applied on the second count strobe after the write. Until then the counter reads its previous value.
- R10: A compare write takes effect in the cycle after the write and reads back at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_stb_i | input | 1 | One-cycle strobe per counting-clock period |
| bus_wr_i | input | 1 | Write request |
| bus_rd_i | input | 1 | Read request |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Registered read data |
| bus_rvalid_o | output | 1 | High the cycle after a read request |
| irq_o | output | NUM_CH | One interrupt line per channel |

## Verification
The hardest states to reach are the counter near all ones, where the wrap flag can fire, and the window in which a counter write is still pending. The bench holds the count strobe low and pulses it one cycle at a time. This shows that a written value stays invisible after one strobe and appears after the second. The same pending-write path then loads a count just below all ones, with the compare value set below it, so the rollover arrives within three ticks and the wrap flag can be checked apart from the match flag.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int IE_BIT   = 6;
  localparam int WRAP_BIT = 14;

  typedef enum logic [1:0] {
    WORD_CTRL = 2'd0,
    WORD_CNT  = 2'd1,
    WORD_CMP  = 2'd2,
    WORD_NONE = 2'd3
  } word_sel_e;

  // strobes per tick for a divider code
  function automatic int unsigned div_ratio(input logic [1:0] code);
    return 32'd8 << (2 * code);
  endfunction

  function automatic int unsigned match_bit(input int unsigned width);
    return (width == 16) ? 7 : 15;
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int unsigned MAX_DIV = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       stb_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  import cmt_pkg::*;

  localparam int unsigned PW = $clog2(MAX_DIV);

  logic [PW-1:0] pc_q;
  logic [PW-1:0] term;

  always_comb begin
    term   = PW'(div_ratio(sel_i) - 1);
    tick_o = run_i & stb_i & (pc_q >= term);
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      pc_q <= '0;
    end else if (stb_i) begin
      pc_q <= tick_o ? '0 : pc_q + 1'b1;
    end
  end

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned MAX_DIV = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             stb_i,
  input  logic             ctrl_wr_i,
  input  logic             cnt_wr_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [15:0]      ctrl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             irq_o
);
  import cmt_pkg::*;

  localparam int unsigned MBIT     = match_bit(CNT_W);
  localparam bit          HAS_WRAP = (CNT_W > 16);

  logic             ie_q;
  logic [1:0]       div_q;
  logic             match_q;
  logic             wrap_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic             pend_q;
  logic             pend_age_q;
  logic [CNT_W-1:0] pend_val_q;
  logic             irq_q;
  logic             tick;
  logic             apply;
  logic             at_cmp;
  logic             at_max;
  logic             hit;
  logic             roll;

  cmt_prescaler #(.MAX_DIV(MAX_DIV)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .run_i (run_i),
    .stb_i (stb_i),
    .sel_i (div_q),
    .tick_o(tick)
  );

  always_comb begin
    apply  = pend_q & pend_age_q & stb_i;
    at_cmp = (cnt_q == cmp_q);
    at_max = &cnt_q;
    hit    = tick & ~apply & at_cmp;
    roll   = tick & ~apply & ~at_cmp & at_max;
  end

  // counter with delayed software load
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (apply) begin
      cnt_q <= pend_val_q;
    end else if (tick) begin
      cnt_q <= at_cmp ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_age_q <= 1'b0;
      pend_val_q <= '0;
    end else if (cnt_wr_i) begin
      pend_q     <= 1'b1;
      pend_age_q <= 1'b0;
      pend_val_q <= wdata_i;
    end else if (pend_q && stb_i) begin
      if (pend_age_q) pend_q <= 1'b0;
      else            pend_age_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
    end else if (cmp_wr_i) begin
      cmp_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= 1'b0;
      div_q   <= 2'd0;
      match_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_wr_i) begin
        ie_q  <= wdata_i[IE_BIT];
        div_q <= wdata_i[1:0];
      end
      match_q <= (match_q & ~(ctrl_wr_i & ~wdata_i[MBIT])) | hit;
      irq_q   <= match_q & ie_q;
    end
  end

  generate
    if (HAS_WRAP) begin : g_wrap
      always_ff @(posedge clk) begin
        if (rst) begin
          wrap_q <= 1'b0;
        end else begin
          wrap_q <= (wrap_q & ~(ctrl_wr_i & ~wdata_i[WRAP_BIT])) | roll;
        end
      end
    end else begin : g_nowrap
      always_comb wrap_q = 1'b0;
    end
  endgenerate

  always_comb begin
    ctrl_o         = '0;
    ctrl_o[MBIT]   = match_q;
    ctrl_o[IE_BIT] = ie_q;
    ctrl_o[1:0]    = div_q;
    if (HAS_WRAP) ctrl_o[WRAP_BIT] = wrap_q;
    cnt_o = cnt_q;
    cmp_o = cmp_q;
    irq_o = irq_q;
  end

  // R3: a stopped channel only changes count through a pending load
  p_stopped_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !apply) |=> $stable(cnt_q));

  // R5: a compare hit restarts the count from zero
  p_hit_restarts_r5: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt_q == '0) && match_q);

  // R7: the match flag only falls on a write of 0 to its bit
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (match_q && !(ctrl_wr_i && !wdata_i[MBIT])) |=> match_q);

  // R9: a counter write never shows in the following cycle on a stopped channel
  p_load_not_early_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr_i && !run_i) |=> $stable(cnt_q));

  // R5: the match flag rises only from a prescaler tick
  p_match_from_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(match_q) |-> $past(tick));

endmodule

// File: rtl/cmt_timer_block.sv
module cmt_timer_block #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CH_SHIFT = 4,
  parameter int unsigned MAX_DIV  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_stb_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic [NUM_CH-1:0] irq_o
);
  import cmt_pkg::*;

  localparam int unsigned WSHIFT = (CNT_W == 16) ? 1 : 2;
  localparam int unsigned CHF_W  = ADDR_W - CH_SHIFT;

  logic [CHF_W-1:0]    ch_field;
  logic [CH_SHIFT-1:0] off;
  logic                aligned;
  word_sel_e           wsel;
  logic                run_hit;
  logic [NUM_CH-1:0]   run_q;
  logic [CNT_W-1:0]    rdata_n;
  logic [CNT_W-1:0]    rdata_q;
  logic                rvalid_q;

  logic [15:0]      ctrl_a [NUM_CH];
  logic [CNT_W-1:0] cnt_a  [NUM_CH];
  logic [CNT_W-1:0] cmp_a  [NUM_CH];
  logic [NUM_CH-1:0] ch_sel;

  always_comb begin
    ch_field = bus_addr_i[ADDR_W-1:CH_SHIFT];
    off      = bus_addr_i[CH_SHIFT-1:0];
    aligned  = (off[WSHIFT-1:0] == '0);
    case (off >> WSHIFT)
      CH_SHIFT'(0): wsel = WORD_CTRL;
      CH_SHIFT'(1): wsel = WORD_CNT;
      CH_SHIFT'(2): wsel = WORD_CMP;
      default:      wsel = WORD_NONE;
    endcase
    run_hit = (ch_field == '0) && (off == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (bus_wr_i && run_hit) begin
      run_q <= bus_wdata_i[NUM_CH-1:0];
    end
  end

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      assign ch_sel[k] = (ch_field == CHF_W'(k + 1)) && aligned;

      cmt_channel #(.CNT_W(CNT_W), .MAX_DIV(MAX_DIV)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run_q[k]),
        .stb_i    (cnt_stb_i),
        .ctrl_wr_i(bus_wr_i && ch_sel[k] && (wsel == WORD_CTRL)),
        .cnt_wr_i (bus_wr_i && ch_sel[k] && (wsel == WORD_CNT)),
        .cmp_wr_i (bus_wr_i && ch_sel[k] && (wsel == WORD_CMP)),
        .wdata_i  (bus_wdata_i),
        .ctrl_o   (ctrl_a[k]),
        .cnt_o    (cnt_a[k]),
        .cmp_o    (cmp_a[k]),
        .irq_o    (irq_o[k])
      );
    end
  endgenerate

  always_comb begin
    rdata_n = '0;
    if (run_hit) rdata_n = CNT_W'(run_q);
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_sel[k]) begin
        case (wsel)
          WORD_CTRL: rdata_n = CNT_W'(ctrl_a[k]);
          WORD_CNT:  rdata_n = cnt_a[k];
          WORD_CMP:  rdata_n = cmp_a[k];
          default:   rdata_n = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd_i;
      if (bus_rd_i) rdata_q <= rdata_n;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  // R2: read data is presented exactly one cycle after a request
  p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rd_i |=> bus_rvalid_o);

endmodule

// File: tb/sim_cmt_timer_block.sv
module sim_cmt_timer_block;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stb = 1'b1;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cmt_timer_block u0 (
    .clk         (clk),
    .rst         (rst),
    .cnt_stb_i   (stb),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .bus_rvalid_o(rvalid),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    if (!rvalid) begin
      errors++;
      $display("FAIL R2 rvalid actual=0 expected=1");
    end
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(8'h18, v); chk("R1 compare", v, 32'hFFFF_FFFF);
    bus_read(8'h10, v); chk("R1 ctrl", v, 32'h0);
    bus_read(8'h14, v); chk("R1 counter", v, 32'h0);
    bus_read(8'h00, v); chk("R1 run", v, 32'h0);
    chk("R1 irq", {30'b0, irq}, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    bus_write(8'h18, 32'd3);
    bus_write(8'h28, 32'h77);
    bus_read(8'h18, v); chk("R10 compare ch0", v, 32'd3);
    bus_read(8'h28, v); chk("R2 compare ch1", v, 32'h77);
    bus_read(8'h1A, v); chk("R2 unaligned", v, 32'h0);
  endtask

  task automatic t_match();
    logic [31:0] v;
    bus_write(8'h10, 32'h0040);
    bus_write(8'h00, 32'h1);
    idle(20);
    bus_read(8'h14, v); chk("R5 count before match", v, 32'd2);
    idle(14);
    bus_read(8'h10, v); chk("R5 match flag", v, 32'h8040);
    chk("R8 irq high", {31'b0, irq[0]}, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    bus_write(8'h00, 32'h0);
    bus_write(8'h10, 32'h8040);
    bus_read(8'h10, v); chk("R7 write one keeps", v, 32'h8040);
    bus_write(8'h10, 32'h0040);
    bus_read(8'h10, v); chk("R7 write zero clears", v, 32'h0040);
    chk("R8 irq low after clear", {31'b0, irq[0]}, 32'h0);
  endtask

  task automatic t_ie_off();
    logic [31:0] v;
    bus_write(8'h00, 32'h1);
    idle(40);
    bus_write(8'h10, 32'h8000);
    bus_write(8'h00, 32'h0);
    bus_read(8'h10, v); chk("R8 flag kept enable off", v, 32'h8000);
    chk("R8 irq low enable off", {31'b0, irq[0]}, 32'h0);
    bus_write(8'h10, 32'h0);
    bus_read(8'h10, v); chk("R7 cleared", v, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] a, b;
    bus_read(8'h14, a);
    idle(30);
    bus_read(8'h14, b); chk("R3 stopped holds", b, a);
    bus_read(8'h24, b); chk("R3 never started", b, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    stb = 1'b0;
    bus_write(8'h24, 32'h1234);
    bus_read(8'h24, v); chk("R9 no strobe yet", v, 32'h0);
    @(negedge clk) stb = 1'b1;
    @(negedge clk) stb = 1'b0;
    bus_read(8'h24, v); chk("R9 after one strobe", v, 32'h0);
    @(negedge clk) stb = 1'b1;
    @(negedge clk) stb = 1'b0;
    bus_read(8'h24, v); chk("R9 after two strobes", v, 32'h1234);
    stb = 1'b1;
  endtask

  task automatic t_div512();
    logic [31:0] v;
    bus_write(8'h24, 32'h0);
    idle(3);
    bus_write(8'h20, 32'h0003);
    bus_write(8'h00, 32'h2);
    idle(600);
    bus_read(8'h24, v); chk("R4 one tick at 512", v, 32'd1);
    idle(500);
    bus_read(8'h24, v); chk("R4 two ticks at 512", v, 32'd2);
    bus_write(8'h00, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    bus_write(8'h20, 32'h0);
    bus_write(8'h28, 32'd5);
    bus_write(8'h24, 32'hFFFF_FFFD);
    idle(3);
    bus_write(8'h00, 32'h2);
    idle(20);
    bus_read(8'h20, v); chk("R6 no wrap yet", v, 32'h0);
    idle(6);
    bus_read(8'h20, v); chk("R6 wrap flag", v, 32'h4000);
    bus_read(8'h24, v); chk("R6 wrapped to zero", v, 32'h0);
    bus_write(8'h00, 32'h0);
    bus_write(8'h20, 32'h0);
    bus_read(8'h20, v); chk("R7 wrap cleared", v, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_match();
    t_clear();
    t_ie_off();
    t_hold();
    t_load();
    t_div512();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule